// File: doc/BRIEF.md
# Line-Rate Format Window Detector

This block decides whether a horizontal sync stream belongs to one video format that software has defined. It runs on a 27 MHz reference clock. It counts how many reference cycles pass while twenty consecutive line periods go by. It then compares that total with a lower and an upper 16-bit limit, each given as a high byte and a low byte. A format is recognised only if the count lies inside the limits, the interlace indication equals the programmed expected value, and the detection enable is set.

The sync input is asynchronous to the reference clock. It passes through a two-flop synchronizer, and the block detects its rising edge. The first rising edge after reset or after enable goes high opens the first window. The rising edge that closes a window also opens the next one, so a steady sync stream yields one result every twenty lines. Each result drives a one-cycle valid strobe, updates the reported count and updates the match flag. The match flag then holds until the next result, until the enable falls, or until the running count saturates.

Top module: `line_window_detect`

## Requirements
- R1: While reset is high and on the first cycle after it, `match_o`, `valid_o` and `count_o` are all zero.
- R2: A window opens on a synchronized rising edge of `hsync_in` and closes on the 20th rising edge after it. When it closes, `count_o` takes the number of reference cycles between the two edges (20 × the line period), and `valid_o` is high for exactly one cycle.
- R3: The edge that closes a window opens the next one, with no gap. A continuous sync stream of N×20+1 edges therefore gives N results, each with the same count.
- R4: `match_o` is set when the count lies within the limits, both ends inclusive. The upper limit is {`hi_msb`,`hi_lsb`} and the lower limit is {`lo_msb`,`lo_lsb`}, with the msb byte in bits 15:8 and the lsb byte in bits 7:0.
- R5: A count one above the upper limit, or one below the lower limit, gives `match_o` = 0. When the lower limit is above the upper limit, no count ever matches.
- R6: When `ilace_in` differs from `ilace_expect` at the cycle a window closes, the result has `match_o` = 0 even though the count lies within the limits.
- R7: While `det_en` is 0, `match_o` is 0 from the next cycle on, `valid_o` stays 0 and no window is open. After `det_en` rises, the first edge opens a new window.
- R8: The running count saturates at 0xFFFF. When it reaches saturation, which happens when sync edges stop arriving, `match_o` is cleared. `count_o` keeps the last reported value, and no result is produced.
- R9: Between results, `count_o` does not change, and `match_o` keeps its value unless R7 or R8 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| ilace_in | input | 1 | Interlace indication from the source |
| det_en | input | 1 | Detection enable |
| hi_msb | input | 8 | Upper limit, bits 15:8 |
| hi_lsb | input | 8 | Upper limit, bits 7:0 |
| lo_msb | input | 8 | Lower limit, bits 15:8 |
| lo_lsb | input | 8 | Lower limit, bits 7:0 |
| ilace_expect | input | 1 | Interlace value that a match requires |
| match_o | output | 1 | Format recognised |
| count_o | output | 16 | Last measured cycle count |
| valid_o | output | 1 | One-cycle strobe when a result is posted |

## Verification
If the period counter is corrupted, results arrive after the wrong number of lines. The count then drifts from 20 × the period, and a strobe appears that the scoreboard did not expect, or an expected strobe is missing. Both show up at the first window that closes, within about twenty line periods. A corrupted cycle count or a wrong comparator shows up on the very next strobe, as a wrong count or a wrong match flag. Faults in the saturation path or the enable path show up on `match_o`: saturation takes at most 65,535 cycles to reach, and a disable takes effect one cycle after `det_en` falls.

// File: rtl/lwd_pkg.sv
`timescale 1ns/1ps
package lwd_pkg;

  typedef enum logic [0:0] {
    MS_IDLE = 1'b0,
    MS_RUN  = 1'b1
  } meter_state_t;

  // inclusive window test on unsigned counts
  function automatic logic in_window(input logic [15:0] cnt,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (cnt >= lo) && (cnt <= hi);
  endfunction

endpackage

// File: rtl/lwd_edge.sv
`timescale 1ns/1ps
module lwd_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES-1:0] sy;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sy[g] <= 1'b0;
        else     sy[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sy[g] <= 1'b0;
        else     sy[g] <= sy[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sy[STAGES-1];
  end

  assign rise_o = sy[STAGES-1] & ~prev;

endmodule

// File: rtl/lwd_meter.sv
`timescale 1ns/1ps
module lwd_meter
  import lwd_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PERIODS = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rise,
  output logic             done_o,
  output logic [CNT_W-1:0] cyc_o,
  output logic             sat_o
);

  localparam int               PW       = (PERIODS > 1) ? $clog2(PERIODS) : 1;
  localparam logic [PW-1:0]    PER_LAST = PW'(PERIODS - 1);
  localparam logic [CNT_W-1:0] CYC_MAX  = '1;
  localparam logic [CNT_W-1:0] CYC_ONE  = CNT_W'(1);

  meter_state_t     st;
  logic [PW-1:0]    per;
  logic [CNT_W-1:0] cyc;
  logic             last_edge;

  assign last_edge = (st == MS_RUN) && rise && (per == PER_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st  <= MS_IDLE;
      per <= '0;
      cyc <= '0;
    end else begin
      case (st)
        MS_IDLE: begin
          if (rise) begin
            st  <= MS_RUN;
            per <= '0;
            cyc <= CYC_ONE;
          end
        end
        MS_RUN: begin
          if (last_edge) begin
            per <= '0;
            cyc <= CYC_ONE;
          end else begin
            if (rise) per <= per + PW'(1);
            if (cyc != CYC_MAX) cyc <= cyc + CYC_ONE;
          end
        end
        default: st <= MS_IDLE;
      endcase
    end
  end

  assign done_o = last_edge;
  assign cyc_o  = cyc;
  assign sat_o  = (st == MS_RUN) && (cyc == CYC_MAX);

endmodule

// File: rtl/lwd_judge.sv
`timescale 1ns/1ps
module lwd_judge
  import lwd_pkg::*;
(
  input  logic        en,
  input  logic        sat,
  input  logic [15:0] cnt,
  input  logic [15:0] lim_lo,
  input  logic [15:0] lim_hi,
  input  logic        ilace_in,
  input  logic        ilace_expect,
  output logic        ok_o
);

  logic win_ok;
  logic il_ok;

  always_comb begin
    win_ok = in_window(cnt, lim_lo, lim_hi);
    il_ok  = (ilace_in == ilace_expect);
    ok_o   = en && !sat && win_ok && il_ok;
  end

endmodule

// File: rtl/line_window_detect.sv
`timescale 1ns/1ps
module line_window_detect #(
  parameter int BYTE_W      = 8,
  parameter int PERIODS     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hsync_in,
  input  logic                ilace_in,
  input  logic                det_en,
  input  logic [BYTE_W-1:0]   hi_msb,
  input  logic [BYTE_W-1:0]   hi_lsb,
  input  logic [BYTE_W-1:0]   lo_msb,
  input  logic [BYTE_W-1:0]   lo_lsb,
  input  logic                ilace_expect,
  output logic                match_o,
  output logic [2*BYTE_W-1:0] count_o,
  output logic                valid_o
);

  localparam int CNT_W = 2 * BYTE_W;

  logic             rise;
  logic             done;
  logic             sat;
  logic [CNT_W-1:0] cyc;
  logic [CNT_W-1:0] lim_hi;
  logic [CNT_W-1:0] lim_lo;
  logic             ok;

  assign lim_hi = {hi_msb, hi_lsb};
  assign lim_lo = {lo_msb, lo_lsb};

  lwd_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .async_in (hsync_in),
    .rise_o   (rise)
  );

  lwd_meter #(.CNT_W(CNT_W), .PERIODS(PERIODS)) u_meter (
    .clk    (clk),
    .rst    (rst),
    .en     (det_en),
    .rise   (rise),
    .done_o (done),
    .cyc_o  (cyc),
    .sat_o  (sat)
  );

  lwd_judge u_judge (
    .en           (det_en),
    .sat          (sat),
    .cnt          (cyc),
    .lim_lo       (lim_lo),
    .lim_hi       (lim_hi),
    .ilace_in     (ilace_in),
    .ilace_expect (ilace_expect),
    .ok_o         (ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_o <= 1'b0;
      valid_o <= 1'b0;
      count_o <= '0;
    end else begin
      valid_o <= done && det_en;
      if (done && det_en) begin
        count_o <= cyc;
        match_o <= ok;
      end else if (!det_en || sat) begin
        match_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lwd_checker.sv
`timescale 1ns/1ps
module lwd_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                det_en,
  input logic                ilace_in,
  input logic                ilace_expect,
  input logic [BYTE_W-1:0]   hi_msb,
  input logic [BYTE_W-1:0]   hi_lsb,
  input logic [BYTE_W-1:0]   lo_msb,
  input logic [BYTE_W-1:0]   lo_lsb,
  input logic                match_o,
  input logic                valid_o,
  input logic [2*BYTE_W-1:0] count_o
);

  logic [2*BYTE_W-1:0] hi_w, lo_w;
  assign hi_w = {hi_msb, hi_lsb};
  assign lo_w = {lo_msb, lo_lsb};

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o) else $error("valid longer than one cycle"); // R2

  AST_OFF_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    !det_en |=> !match_o) else $error("match while disabled"); // R7

  AST_OFF_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !det_en |=> !valid_o) else $error("result while disabled"); // R7

  AST_MATCH_IN_LIMITS: assert property (@(posedge clk) disable iff (rst)
    (valid_o && match_o) |-> (count_o >= $past(lo_w) && count_o <= $past(hi_w)))
    else $error("match outside limits"); // R4

  AST_MATCH_ILACE: assert property (@(posedge clk) disable iff (rst)
    (valid_o && match_o) |-> ($past(ilace_in) == $past(ilace_expect)))
    else $error("match with interlace mismatch"); // R6

  AST_SAT_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    (valid_o && (count_o == '1)) |-> !match_o) else $error("saturated match"); // R8

  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(count_o)) else $error("count moved between results"); // R9

endmodule

bind line_window_detect lwd_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .det_en       (det_en),
  .ilace_in     (ilace_in),
  .ilace_expect (ilace_expect),
  .hi_msb       (hi_msb),
  .hi_lsb       (hi_lsb),
  .lo_msb       (lo_msb),
  .lo_lsb       (lo_lsb),
  .match_o      (match_o),
  .valid_o      (valid_o),
  .count_o      (count_o)
);

// File: tb/line_window_detect_test.sv
`timescale 1ns/1ps
module line_window_detect_test;

  localparam int CLK_PERIOD = 37;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [15:0] cnt;
    logic        mt;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync_in = 1'b0;
  logic        ilace_in = 1'b0;
  logic        det_en = 1'b0;
  logic [7:0]  hi_msb = '0, hi_lsb = '0, lo_msb = '0, lo_lsb = '0;
  logic        ilace_expect = 1'b0;
  logic        match_o, valid_o;
  logic [15:0] count_o;

  int   checks = 0;
  int   errors = 0;
  int   cyc_n  = 0;
  exp_t sb[$];

  line_window_detect uut (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .ilace_in(ilace_in),
    .det_en(det_en), .hi_msb(hi_msb), .hi_lsb(hi_lsb), .lo_msb(lo_msb),
    .lo_lsb(lo_lsb), .ilace_expect(ilace_expect), .match_o(match_o),
    .count_o(count_o), .valid_o(valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc_n, WATCHDOG);
      summary();
    end
  end

  // monitor: compare every posted result with the scoreboard head
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected result actual=%0h expected=none", count_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " count"}, 32'(count_o), 32'(e.cnt));
        check({e.req, " match"}, 32'(match_o), 32'(e.mt));
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic set_limits(input logic [15:0] lo, input logic [15:0] hi);
    {lo_msb, lo_lsb} = lo;
    {hi_msb, hi_lsb} = hi;
  endtask

  task automatic edges(input int p, input int k);
    for (int i = 0; i < k; i++) begin
      hsync_in = 1'b1; tick(p / 2);
      hsync_in = 1'b0; tick(p - p / 2);
    end
  endtask

  // driver: restart detection, push expected results, then drive the sync
  task automatic run(input string req, input int p, input int n);
    logic [15:0] c;
    logic [15:0] lo, hi;
    det_en = 1'b0; tick(2);
    det_en = 1'b1; tick(2);
    c  = 16'(20 * p);
    lo = {lo_msb, lo_lsb};
    hi = {hi_msb, hi_lsb};
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.cnt = c;
      e.mt  = (c >= lo) && (c <= hi) && (ilace_in == ilace_expect);
      e.req = req;
      sb.push_back(e);
    end
    edges(p, 20 * n + 1);
    tick(10);
    check({req, " all results posted"}, 32'(sb.size()), 32'd0);
  endtask

  initial begin
    tick(1);
    check("R1 match in reset", 32'(match_o), 0);
    check("R1 valid in reset", 32'(valid_o), 0);
    tick(3);
    rst = 1'b0;
    tick(1);
    check("R1 count after reset", 32'(count_o), 0);
    check("R1 match after reset", 32'(match_o), 0);

    // exact boundary both ends, 0x0190 spans both bytes
    set_limits(16'd400, 16'd400);
    run("R2 R3 R4 exact", 20, 3);
    set_limits(16'd380, 16'd420);
    run("R4 low edge", 19, 1);
    run("R4 high edge", 21, 1);
    set_limits(16'd380, 16'd419);
    run("R5 above high", 21, 1);
    set_limits(16'd381, 16'd500);
    run("R5 below low", 19, 1);
    set_limits(16'd500, 16'd300);
    run("R5 crossed limits", 20, 2);

    set_limits(16'd0, 16'hFFFE);
    ilace_in = 1'b1; ilace_expect = 1'b0;
    run("R6 interlace differs", 24, 1);
    ilace_expect = 1'b1;
    run("R6 interlace agrees", 24, 1);

    // match holds, then disable clears it and suppresses results
    tick(20);
    check("R9 match held", 32'(match_o), 1);
    check("R9 count held", 32'(count_o), 32'd480);
    det_en = 1'b0; tick(1);
    check("R7 match cleared", 32'(match_o), 0);
    edges(20, 45);
    tick(5);
    check("R7 no match while disabled", 32'(match_o), 0);

    // enable and measure a different rate, then starve the sync
    set_limits(16'd0, 16'hFFFF);
    ilace_in = 1'b0; ilace_expect = 1'b0;
    run("R7 R3 re-enable", 30, 2);
    check("R8 match before starve", 32'(match_o), 1);
    tick(66000);
    check("R8 match cleared on saturation", 32'(match_o), 0);
    check("R8 count kept", 32'(count_o), 32'd600);

    check("R2 scoreboard empty", 32'(sb.size()), 0);
    summary();
  end

endmodule